// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This unit holds the 16-bit stack pointer of a small processor core. Software sees it as two byte-wide registers, a high half and a low half. Each half can be read at any time and written on its own. The core drives four one-cycle strobes: a data push, a data pop, a return-address push (from a call or an interrupt entry) and a return-address pop (from a return). For each strobe the unit returns, in the same cycle, the SRAM byte addresses to use. On the next clock edge it moves the pointer by one or by two bytes.

The stack grows toward lower addresses. The pointer always names the next free byte. A push writes at the pointer and then moves it down. A pop first moves the pointer up and then reads. A return address takes two bytes. Its low byte goes to the pointer and its high byte to the pointer minus one. A return-address pop reads the high byte at pointer plus one and the low byte at pointer plus two.

A combinational warning flags any push made while the pointer is at or below the lowest legal stack placement, address 0x60. Software writes always take precedence over a stack event in the same cycle.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset both halves of the pointer read 0x00, and the floor warning is low when no push is requested.
- R2: A data push (`ev_push`) drives `mem_we` high and `addr_a` equal to the current pointer in the same cycle, and the pointer reads one lower after the next clock edge.
- R3: A return-address push (`ev_call`) drives `mem_we` high, with `addr_a` equal to the pointer (low byte of the return address) and `addr_b` equal to the pointer minus one (high byte). The pointer reads two lower after the next edge.
- R4: A data pop (`ev_pop`) drives `mem_re` high and `addr_a` equal to the pointer plus one, and the pointer reads one higher after the next edge.
- R5: A return-address pop (`ev_ret`) drives `mem_re` high, with `addr_b` equal to the pointer plus one (high byte) and `addr_a` equal to the pointer plus two (low byte). The pointer reads two higher after the next edge.
- R6: A software write with `sw_wr_hi` loads `sw_wdata` into bits 15:8, and one with `sw_wr_lo` loads it into bits 7:0. The other half is unchanged, and the new value reads back on `sp_hi`/`sp_lo` after the next edge.
- R7: When a software write falls in the same cycle as a stack event, the written half takes `sw_wdata` and the event's pointer change is discarded, so an unwritten half holds its value.
- R8: When several strobes are high together, exactly one takes effect, in the priority order call, then return, then data push, then data pop.
- R9: `floor_warn` is high in the cycle of a data or return-address push when the pointer is at or below 0x60. It is low for pops, for idle cycles and for pushes at 0x61 or above.
- R10: Pointer arithmetic wraps modulo 2^16: a data push at 0x0000 gives 0xFFFF, and a data pop at 0xFFFF gives 0x0000.
- R11: With no strobe and no software write, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_hi | input | 1 | Software write strobe for the high half |
| sw_wr_lo | input | 1 | Software write strobe for the low half |
| sw_wdata | input | 8 | Software write data |
| ev_push | input | 1 | Data push strobe |
| ev_pop | input | 1 | Data pop strobe |
| ev_call | input | 1 | Return-address push strobe (call or interrupt entry) |
| ev_ret | input | 1 | Return-address pop strobe (return or interrupt return) |
| sp_hi | output | 8 | Pointer bits 15:8 |
| sp_lo | output | 8 | Pointer bits 7:0 |
| addr_a | output | 16 | Single-byte address, or low byte of a return address |
| addr_b | output | 16 | High byte of a return address (equals addr_a for one-byte events) |
| mem_we | output | 1 | SRAM write for this cycle's push |
| mem_re | output | 1 | SRAM read for this cycle's pop |
| floor_warn | output | 1 | Push requested at or below the stack floor |

## Verification
The addresses, `mem_we`, `mem_re` and `floor_warn` are combinational from the current pointer and the strobes, so they are due in the cycle of the stimulus. The bench drives each strobe on a falling edge and samples these outputs two nanoseconds later, before the rising edge. The pointer change goes through one register and appears after that rising edge. The bench clears the strobes on the following falling edge and reads `sp_hi`/`sp_lo` just after it, so every pointer check sits exactly one edge after its stimulus.

// File: rtl/sp_pkg.sv
// Shared types for the stack pointer unit.
package sp_pkg;
    // Resolved stack action for one cycle, after priority among strobes.
    typedef enum logic [2:0] {
        SK_NONE  = 3'd0,
        SK_PUSH1 = 3'd1,
        SK_PUSH2 = 3'd2,
        SK_POP1  = 3'd3,
        SK_POP2  = 3'd4
    } step_kind_t;
endpackage

// File: rtl/sp_event_decode.sv
// Turns the four stack strobes into a single resolved action.
// Assumes: strobes are one-cycle pulses; when several are high together,
// call wins over return, return over data push, data push over data pop.
module sp_event_decode
    import sp_pkg::*;
(
    input  logic       ev_push,
    input  logic       ev_pop,
    input  logic       ev_call,
    input  logic       ev_ret,
    output step_kind_t kind
);
    // Fixed priority selection of the action to perform.
    always_comb begin
        if (ev_call)      kind = SK_PUSH2;
        else if (ev_ret)  kind = SK_POP2;
        else if (ev_push) kind = SK_PUSH1;
        else if (ev_pop)  kind = SK_POP1;
        else              kind = SK_NONE;
    end
endmodule

// File: rtl/sp_addr_gen.sv
// Forms SRAM byte addresses and read/write enables from the current
// pointer and the resolved action.
// Assumes: the pointer names the next free byte (push writes then
// decrements, pop increments then reads).
module sp_addr_gen
    import sp_pkg::*;
#(
    parameter int SP_W = 16
) (
    input  logic [SP_W-1:0] sp,
    input  step_kind_t      kind,
    output logic [SP_W-1:0] addr_a,
    output logic [SP_W-1:0] addr_b,
    output logic            mem_we,
    output logic            mem_re
);
    localparam logic [SP_W-1:0] ONE = SP_W'(1);
    localparam logic [SP_W-1:0] TWO = SP_W'(2);

    // Address and enable selection per action.
    always_comb begin
        addr_a = '0;
        addr_b = '0;
        mem_we = 1'b0;
        mem_re = 1'b0;
        unique case (kind)
            SK_PUSH1: begin
                addr_a = sp;
                addr_b = sp;
                mem_we = 1'b1;
            end
            SK_PUSH2: begin
                addr_a = sp;
                addr_b = sp - ONE;
                mem_we = 1'b1;
            end
            SK_POP1: begin
                addr_a = sp + ONE;
                addr_b = sp + ONE;
                mem_re = 1'b1;
            end
            SK_POP2: begin
                addr_a = sp + TWO;
                addr_b = sp + ONE;
                mem_re = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sp_floor_guard.sv
// Raises a warning when a push is requested with the pointer at or below
// the lowest legal stack placement.
// Assumes: FLOOR fits in SP_W bits.
module sp_floor_guard
    import sp_pkg::*;
#(
    parameter int          SP_W  = 16,
    parameter int unsigned FLOOR = 32'h60
) (
    input  logic [SP_W-1:0] sp,
    input  step_kind_t      kind,
    output logic            floor_warn
);
    localparam logic [SP_W-1:0] FLOOR_V = SP_W'(FLOOR);

    // Compare only while a push of either size is in progress.
    always_comb begin
        floor_warn = ((kind == SK_PUSH1) || (kind == SK_PUSH2)) && (sp <= FLOOR_V);
    end
endmodule

// File: rtl/sp_reg.sv
// Pointer register split into byte-wide halves. Software writes take
// precedence: any write in a cycle discards that cycle's stack step.
// Assumes: SP_W is a multiple of HALVES.
module sp_reg
    import sp_pkg::*;
#(
    parameter int SP_W   = 16,
    parameter int HALVES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [HALVES-1:0]        sw_wr,
    input  logic [SP_W/HALVES-1:0]   sw_wdata,
    input  step_kind_t               kind,
    output logic [SP_W-1:0]          sp
);
    localparam int HALF_W = SP_W / HALVES;

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_step;

    // Arithmetic next value for the resolved action, modulo 2^SP_W.
    always_comb begin
        unique case (kind)
            SK_PUSH1: sp_step = sp_q - SP_W'(1);
            SK_PUSH2: sp_step = sp_q - SP_W'(2);
            SK_POP1:  sp_step = sp_q + SP_W'(1);
            SK_POP2:  sp_step = sp_q + SP_W'(2);
            default:  sp_step = sp_q;
        endcase
    end

    // Register update: reset, else software write per half, else step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (|sw_wr) begin
            for (int h = 0; h < HALVES; h++) begin
                if (sw_wr[h]) sp_q[h*HALF_W +: HALF_W] <= sw_wdata;
            end
        end else begin
            sp_q <= sp_step;
        end
    end

    assign sp = sp_q;
endmodule

// File: rtl/stack_ptr_unit.sv
// Top of the stack pointer unit: byte-wide software access to a 16-bit
// downward-growing pointer, stack event stepping and SRAM addressing.
// Assumes: synchronous active-low reset; strobes sampled on rising edge.
module stack_ptr_unit
    import sp_pkg::*;
#(
    parameter int          SP_W  = 16,
    parameter int unsigned FLOOR = 32'h60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_wr_hi,
    input  logic        sw_wr_lo,
    input  logic [7:0]  sw_wdata,
    input  logic        ev_push,
    input  logic        ev_pop,
    input  logic        ev_call,
    input  logic        ev_ret,
    output logic [7:0]  sp_hi,
    output logic [7:0]  sp_lo,
    output logic [15:0] addr_a,
    output logic [15:0] addr_b,
    output logic        mem_we,
    output logic        mem_re,
    output logic        floor_warn
);
    localparam int HALVES = 2;
    localparam int HALF_W = SP_W / HALVES;

    step_kind_t       kind;
    logic [SP_W-1:0]  sp;

    sp_event_decode u_dec (
        .ev_push (ev_push),
        .ev_pop  (ev_pop),
        .ev_call (ev_call),
        .ev_ret  (ev_ret),
        .kind    (kind)
    );

    sp_reg #(.SP_W(SP_W), .HALVES(HALVES)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    ({sw_wr_hi, sw_wr_lo}),
        .sw_wdata (sw_wdata),
        .kind     (kind),
        .sp       (sp)
    );

    sp_addr_gen #(.SP_W(SP_W)) u_addr (
        .sp     (sp),
        .kind   (kind),
        .addr_a (addr_a),
        .addr_b (addr_b),
        .mem_we (mem_we),
        .mem_re (mem_re)
    );

    sp_floor_guard #(.SP_W(SP_W), .FLOOR(FLOOR)) u_floor (
        .sp         (sp),
        .kind       (kind),
        .floor_warn (floor_warn)
    );

    assign sp_hi = sp[SP_W-1:HALF_W];
    assign sp_lo = sp[HALF_W-1:0];
endmodule

// File: rtl/stack_ptr_unit_chk.sv
// Port-level protocol checks for the stack pointer unit, bound to the top.
module stack_ptr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_wr_hi,
    input logic        sw_wr_lo,
    input logic [7:0]  sw_wdata,
    input logic        ev_push,
    input logic        ev_pop,
    input logic        ev_call,
    input logic        ev_ret,
    input logic [7:0]  sp_hi,
    input logic [7:0]  sp_lo,
    input logic        mem_we,
    input logic        mem_re,
    input logic        floor_warn
);
    logic [15:0] sp_v;
    logic        no_wr;
    assign sp_v  = {sp_hi, sp_lo};
    assign no_wr = !sw_wr_hi && !sw_wr_lo;

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_push && !ev_call && !ev_ret && no_wr) |=> (sp_v == 16'($past(sp_v) - 16'd1))); // R2
    AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_call && no_wr) |=> (sp_v == 16'($past(sp_v) - 16'd2))); // R3
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pop && !ev_push && !ev_call && !ev_ret && no_wr) |=> (sp_v == 16'($past(sp_v) + 16'd1))); // R4
    AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ret && !ev_call && no_wr) |=> (sp_v == 16'($past(sp_v) + 16'd2))); // R5
    AST_SW_LO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_lo |=> (sp_lo == $past(sw_wdata))); // R7
    AST_SW_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_hi |=> (sp_hi == $past(sw_wdata))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_push && !ev_pop && !ev_call && !ev_ret && no_wr) |=> $stable(sp_v)); // R11
    AST_WARN_ONLY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        floor_warn |-> ((ev_push || ev_call) && !mem_re)); // R9
    AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R8
endmodule

bind stack_ptr_unit stack_ptr_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr_hi   (sw_wr_hi),
    .sw_wr_lo   (sw_wr_lo),
    .sw_wdata   (sw_wdata),
    .ev_push    (ev_push),
    .ev_pop     (ev_pop),
    .ev_call    (ev_call),
    .ev_ret     (ev_ret),
    .sp_hi      (sp_hi),
    .sp_lo      (sp_lo),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .floor_warn (floor_warn)
);

// File: tb/stack_ptr_unit_test.sv
module stack_ptr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_hi = 1'b0, sw_wr_lo = 1'b0;
    logic [7:0]  sw_wdata = 8'h00;
    logic        ev_push = 1'b0, ev_pop = 1'b0, ev_call = 1'b0, ev_ret = 1'b0;
    logic [7:0]  sp_hi, sp_lo;
    logic [15:0] addr_a, addr_b;
    logic        mem_we, mem_re, floor_warn;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] c_a, c_b;
    logic        c_we, c_re, c_warn;

    always #10 clk = ~clk;

    stack_ptr_unit uut (
        .clk(clk), .rst_n(rst_n), .sw_wr_hi(sw_wr_hi), .sw_wr_lo(sw_wr_lo),
        .sw_wdata(sw_wdata), .ev_push(ev_push), .ev_pop(ev_pop),
        .ev_call(ev_call), .ev_ret(ev_ret), .sp_hi(sp_hi), .sp_lo(sp_lo),
        .addr_a(addr_a), .addr_b(addr_b), .mem_we(mem_we), .mem_re(mem_re),
        .floor_warn(floor_warn)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One stimulus cycle: drive on a falling edge, capture combinational
    // outputs before the rising edge, clear on the next falling edge.
    task automatic pulse(input logic push, input logic pop, input logic call,
                         input logic ret, input logic whi, input logic wlo,
                         input logic [7:0] wd);
        @(negedge clk);
        ev_push = push; ev_pop = pop; ev_call = call; ev_ret = ret;
        sw_wr_hi = whi; sw_wr_lo = wlo; sw_wdata = wd;
        #2;
        c_a = addr_a; c_b = addr_b; c_we = mem_we; c_re = mem_re; c_warn = floor_warn;
        @(negedge clk);
        ev_push = 0; ev_pop = 0; ev_call = 0; ev_ret = 0;
        sw_wr_hi = 0; sw_wr_lo = 0; sw_wdata = 8'h00;
        #2;
    endtask

    task automatic t_reset;
        chk("R1 sp", {sp_hi, sp_lo}, 16'h0000);
        chk("R1 warn", {15'd0, floor_warn}, 16'd0);
    endtask

    task automatic t_sw_write;
        pulse(0, 0, 0, 0, 1, 0, 8'h08);
        chk("R6 hi write", {sp_hi, sp_lo}, 16'h0800);
        pulse(0, 0, 0, 0, 0, 1, 8'hFF);
        chk("R6 lo write keeps hi", {sp_hi, sp_lo}, 16'h08FF);
    endtask

    task automatic t_push_pop;
        pulse(1, 0, 0, 0, 0, 0, 8'h00);
        chk("R2 addr_a", c_a, 16'h08FF);
        chk("R2 we", {14'd0, c_we, c_re}, 16'd2);
        chk("R2 sp", {sp_hi, sp_lo}, 16'h08FE);
        pulse(0, 0, 1, 0, 0, 0, 8'h00);
        chk("R3 addr_a low byte", c_a, 16'h08FE);
        chk("R3 addr_b high byte", c_b, 16'h08FD);
        chk("R3 we", {15'd0, c_we}, 16'd1);
        chk("R3 sp", {sp_hi, sp_lo}, 16'h08FC);
        pulse(0, 0, 0, 1, 0, 0, 8'h00);
        chk("R5 addr_b high byte", c_b, 16'h08FD);
        chk("R5 addr_a low byte", c_a, 16'h08FE);
        chk("R5 re", {14'd0, c_we, c_re}, 16'd1);
        chk("R5 sp", {sp_hi, sp_lo}, 16'h08FE);
        pulse(0, 1, 0, 0, 0, 0, 8'h00);
        chk("R4 addr_a", c_a, 16'h08FF);
        chk("R4 re", {15'd0, c_re}, 16'd1);
        chk("R4 sp", {sp_hi, sp_lo}, 16'h08FF);
        pulse(0, 0, 0, 0, 0, 0, 8'h00);
        chk("R11 idle hold", {sp_hi, sp_lo}, 16'h08FF);
    endtask

    task automatic t_priority;
        pulse(1, 1, 1, 0, 0, 0, 8'h00);
        chk("R8 call wins", {sp_hi, sp_lo}, 16'h08FD);
        pulse(1, 0, 0, 1, 0, 0, 8'h00);
        chk("R8 ret over push", {sp_hi, sp_lo}, 16'h08FF);
        pulse(1, 1, 0, 0, 0, 0, 8'h00);
        chk("R8 push over pop", {sp_hi, sp_lo}, 16'h08FE);
    endtask

    task automatic t_conflict;
        pulse(0, 0, 1, 0, 0, 1, 8'h10);
        chk("R7 lo write beats call", {sp_hi, sp_lo}, 16'h0810);
        pulse(1, 0, 0, 0, 1, 0, 8'h00);
        chk("R7 hi write beats push", {sp_hi, sp_lo}, 16'h0010);
    endtask

    task automatic t_floor;
        pulse(1, 0, 0, 0, 0, 0, 8'h00);
        chk("R9 warn at 0x10", {15'd0, c_warn}, 16'd1);
        pulse(0, 0, 0, 0, 0, 1, 8'h61);
        pulse(1, 0, 0, 0, 0, 0, 8'h00);
        chk("R9 no warn at 0x61", {15'd0, c_warn}, 16'd0);
        chk("R9 sp", {sp_hi, sp_lo}, 16'h0060);
        pulse(0, 0, 1, 0, 0, 0, 8'h00);
        chk("R9 warn at 0x60", {15'd0, c_warn}, 16'd1);
        pulse(0, 1, 0, 0, 0, 0, 8'h00);
        chk("R9 no warn on pop", {15'd0, c_warn}, 16'd0);
        chk("R9 sp after pop", {sp_hi, sp_lo}, 16'h005F);
    endtask

    task automatic t_wrap;
        pulse(0, 0, 0, 0, 0, 1, 8'h00);
        pulse(1, 0, 0, 0, 0, 0, 8'h00);
        chk("R10 push wraps", {sp_hi, sp_lo}, 16'hFFFF);
        pulse(0, 1, 0, 0, 0, 0, 8'h00);
        chk("R10 pop addr", c_a, 16'h0000);
        chk("R10 pop wraps", {sp_hi, sp_lo}, 16'h0000);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        t_reset();
        t_sw_write();
        t_push_pop();
        t_priority();
        t_conflict();
        t_floor();
        t_wrap();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule